// File: doc/BRIEF.md
# Pin Event Detector

This block watches a set of digital input pins and turns activity on each of them into a sticky event flag. Every pin has its own 4-bit mode code that picks one of three things. The pin can be ignored. It can report edges (rising, falling or both) as a DMA request. It can report edges, or a held logic level, as an interrupt. Each pin input is brought into the clock domain through a synchronizer chain. An edge is found by comparing the synchronized value with the value it had one cycle earlier.

Each pin's flag stays set until it is cleared. Software clears it with a write-1 strobe in any mode. In a DMA mode, a transfer-complete strobe from the DMA engine also clears it. In the level modes the flag is re-armed on the cycle after a clear if the pin is still at the active level. All pins in interrupt modes feed one combined interrupt line. Pins in DMA modes each drive their own request line. Register decoding and the DMA engine itself sit outside this block.

Top module: `pin_event_detect`

## Requirements
- R1: After reset every flag, every DMA request and the combined interrupt are 0.
- R2: A pin with mode code 0000, or with any code not listed in R3 to R6 (for example 0101), never sets its flag.
- R3: Codes 0001 (DMA) and 1001 (interrupt) set the flag on a rising edge. The flag rises at the third rising clock edge after the pin changes: two synchronizer stages and then the flag register.
- R4: Codes 0010 (DMA) and 1010 (interrupt) set the flag on a falling edge, with the same latency as R3.
- R5: Codes 0011 (DMA) and 1011 (interrupt) set the flag on either edge, with the same latency as R3.
- R6: Code 1000 sets the flag while the synchronized pin is 0. Code 1100 sets the flag while it is 1. A pin at the inactive level does not set the flag.
- R7: While a pin's code is 0001, 0010 or 0011, its DMA request equals its flag and the pin does not drive the combined interrupt. In all other codes its DMA request is 0.
- R8: The combined interrupt is the OR of the flags of all pins whose code is 1000, 1001, 1010, 1011 or 1100. It follows a code change without waiting for a clock edge.
- R9: A DMA-done strobe clears the pin's flag at the next clock edge in a DMA mode. In interrupt modes it has no effect on the flag.
- R10: A software clear strobe clears the pin's flag at the next clock edge in any mode.
- R11: An edge detected in the same cycle as a clear leaves the flag set.
- R12: In a level mode, a clear while the pin stays at the active level drops the flag for exactly one cycle, and then the flag is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Raw pin inputs, asynchronous to clk |
| mode_code | input | 4*NUM_PINS | Per-pin mode code; pin p uses bits [4p+3:4p] |
| sw_clear | input | NUM_PINS | Software write-1 clear strobe per pin |
| dma_done | input | NUM_PINS | DMA transfer-complete strobe per pin |
| flag | output | NUM_PINS | Per-pin sticky event flag |
| dma_req | output | NUM_PINS | Per-pin DMA request |
| irq | output | 1 | Combined interrupt line |

## Verification
On every cycle the assertions check four things. An edge that meets a clear keeps the flag set. A software clear with no edge drops the flag. An interrupt-mode flag survives everything except a software clear. A disabled pin never raises its flag. They also check that a DMA request only appears together with its flag and never on a pin that contributes to the interrupt. Some properties span several cycles and need scenario stimulus: the exact three-edge latency through the synchronizer, the one-cycle dip and re-arm of a level-mode flag after a clear, and the interrupt following a mode change with no clock edge. The bench's reference model and directed scenarios cover these.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

   localparam int CODE_W = 4;

   // Mode code values; the numeric encoding is part of the block's interface.
   localparam logic [CODE_W-1:0] EV_OFF      = 4'b0000;
   localparam logic [CODE_W-1:0] EV_DMA_RISE = 4'b0001;
   localparam logic [CODE_W-1:0] EV_DMA_FALL = 4'b0010;
   localparam logic [CODE_W-1:0] EV_DMA_BOTH = 4'b0011;
   localparam logic [CODE_W-1:0] EV_IRQ_LOW  = 4'b1000;
   localparam logic [CODE_W-1:0] EV_IRQ_RISE = 4'b1001;
   localparam logic [CODE_W-1:0] EV_IRQ_FALL = 4'b1010;
   localparam logic [CODE_W-1:0] EV_IRQ_BOTH = 4'b1011;
   localparam logic [CODE_W-1:0] EV_IRQ_HIGH = 4'b1100;

   // Decoded per-pin behaviour
   typedef struct packed {
      logic to_dma;    // flag is routed to the DMA request
      logic to_irq;    // flag is routed to the combined interrupt
      logic on_rise;
      logic on_fall;
      logic on_low;
      logic on_high;
   } ev_mode_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pin_mode_decode.sv
module pin_mode_decode
   import pin_evt_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   output ev_mode_t          mode
);

   always_comb begin
      mode = '0;
      unique case (code)
         EV_DMA_RISE: begin mode.to_dma = 1'b1; mode.on_rise = 1'b1; end
         EV_DMA_FALL: begin mode.to_dma = 1'b1; mode.on_fall = 1'b1; end
         EV_DMA_BOTH: begin mode.to_dma = 1'b1; mode.on_rise = 1'b1; mode.on_fall = 1'b1; end
         EV_IRQ_LOW:  begin mode.to_irq = 1'b1; mode.on_low  = 1'b1; end
         EV_IRQ_RISE: begin mode.to_irq = 1'b1; mode.on_rise = 1'b1; end
         EV_IRQ_FALL: begin mode.to_irq = 1'b1; mode.on_fall = 1'b1; end
         EV_IRQ_BOTH: begin mode.to_irq = 1'b1; mode.on_rise = 1'b1; mode.on_fall = 1'b1; end
         EV_IRQ_HIGH: begin mode.to_irq = 1'b1; mode.on_high = 1'b1; end
         default:     mode = '0;   // EV_OFF and every unlisted code
      endcase
   end

endmodule

// File: rtl/pin_flag_cell.sv
module pin_flag_cell
   import pin_evt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     level,      // synchronized pin value
   input  ev_mode_t mode,
   input  logic     sw_clear,
   input  logic     dma_done,
   output logic     flag,
   output logic     dma_req,
   output logic     irq_req
);

   logic prev_q;
   logic flag_q;
   logic rise, fall;
   logic edge_ev;
   logic level_hit;
   logic clr;
   logic flag_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise      = level & ~prev_q;
   assign fall      = ~level & prev_q;
   assign edge_ev   = (mode.on_rise & rise) | (mode.on_fall & fall);
   assign level_hit = (mode.on_low & ~level) | (mode.on_high & level);
   assign clr       = sw_clear | (dma_done & mode.to_dma);

   // An edge always wins. A held level is suppressed for the clearing cycle only,
   // so the flag re-arms one cycle later.
   assign flag_d = edge_ev | ((level_hit | flag_q) & ~clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag    = flag_q;
   assign dma_req = flag_q & mode.to_dma;
   assign irq_req = flag_q & mode.to_irq;

   // R11
   edge_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_ev |=> flag_q);

   // R10
   sw_clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clear && !edge_ev) |=> !flag_q);

   // R9
   irq_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !mode.to_dma && !sw_clear) |=> flag_q);

   // R2
   off_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !mode.on_rise && !mode.on_fall && !mode.on_low && !mode.on_high) |=> !flag_q);

   // R7
   dma_req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (flag_q && !irq_req));

endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
   import pin_evt_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PINS-1:0]        pin_in,
   input  logic [NUM_PINS*CODE_W-1:0] mode_code,
   input  logic [NUM_PINS-1:0]        sw_clear,
   input  logic [NUM_PINS-1:0]        dma_done,
   output logic [NUM_PINS-1:0]        flag,
   output logic [NUM_PINS-1:0]        dma_req,
   output logic                       irq
);

   generate
      if (NUM_PINS < 1 || NUM_PINS > 64) begin : g_bad_pins
         $error("pin_event_detect: NUM_PINS must be 1..64");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("pin_event_detect: SYNC_STAGES must be 2..4");
      end
   endgenerate

   logic [NUM_PINS-1:0] synced;
   logic [NUM_PINS-1:0] irq_vec;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      ev_mode_t mode;

      pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pin_in[p]),
         .q     (synced[p])
      );

      pin_mode_decode u_dec (
         .code (mode_code[p*CODE_W +: CODE_W]),
         .mode (mode)
      );

      pin_flag_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .level    (synced[p]),
         .mode     (mode),
         .sw_clear (sw_clear[p]),
         .dma_done (dma_done[p]),
         .flag     (flag[p]),
         .dma_req  (dma_req[p]),
         .irq_req  (irq_vec[p])
      );
   end

   assign irq = |irq_vec;

   // R8
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|flag));

   // R7
   dma_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dma_req & ~flag) == '0));

endmodule

// File: tb/tb_pin_event_detect.sv
module tb_pin_event_detect;

   localparam int PERIOD = 10;
   localparam int NP     = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   pin_in = '0;
   logic [NP*4-1:0] mode_code = '0;
   logic [NP-1:0]   sw_clear = '0;
   logic [NP-1:0]   dma_done = '0;
   logic [NP-1:0]   flag;
   logic [NP-1:0]   dma_req;
   logic            irq;

   int checks = 0;
   int fails  = 0;

   always #(PERIOD/2) clk = ~clk;

   pin_event_detect #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode_code(mode_code),
      .sw_clear(sw_clear), .dma_done(dma_done),
      .flag(flag), .dma_req(dma_req), .irq(irq)
   );

   // ---------------- reference model ----------------
   bit m_s0 [NP];
   bit m_s1 [NP];
   bit m_prev [NP];
   bit m_flag [NP];

   function automatic bit is_dma(logic [3:0] c);
      return (c == 4'd1 || c == 4'd2 || c == 4'd3);
   endfunction
   function automatic bit is_irq(logic [3:0] c);
      return (c == 4'd8 || c == 4'd9 || c == 4'd10 || c == 4'd11 || c == 4'd12);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin
            m_s0[p] = 0; m_s1[p] = 0; m_prev[p] = 0; m_flag[p] = 0;
         end
      end else begin
         for (int p = 0; p < NP; p++) begin
            logic [3:0] c;
            bit cur, r, f, want_r, want_f, lvl_hit, ev, clr;
            c = mode_code[p*4 +: 4];
            cur = m_s1[p];
            r = cur && !m_prev[p];
            f = !cur && m_prev[p];
            want_r = (c == 4'd1 || c == 4'd3 || c == 4'd9  || c == 4'd11);
            want_f = (c == 4'd2 || c == 4'd3 || c == 4'd10 || c == 4'd11);
            lvl_hit = (c == 4'd8 && !cur) || (c == 4'd12 && cur);
            ev  = (want_r && r) || (want_f && f);
            clr = sw_clear[p] || (dma_done[p] && is_dma(c));
            if (ev)           m_flag[p] = 1;
            else if (clr)     m_flag[p] = 0;
            else if (lvl_hit) m_flag[p] = 1;
            m_prev[p] = m_s1[p];
            m_s1[p]   = m_s0[p];
            m_s0[p]   = pin_in[p];
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare with the model every cycle, shortly after the falling edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         logic [NP-1:0] ef, ed;
         logic ei;
         ei = 0;
         for (int p = 0; p < NP; p++) begin
            ef[p] = m_flag[p];
            ed[p] = m_flag[p] && is_dma(mode_code[p*4 +: 4]);
            if (m_flag[p] && is_irq(mode_code[p*4 +: 4])) ei = 1;
         end
         chk(flag == ef,    "model flag R3 R4 R5 R6 R9 R10 R11 R12", int'(flag), int'(ef));
         chk(dma_req == ed, "model dma_req R7", int'(dma_req), int'(ed));
         chk(irq == ei,     "model irq R8", int'(irq), int'(ei));
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic set_code(input int p, input logic [3:0] c);
      mode_code[p*4 +: 4] = c;
   endtask
   task automatic pulse_clear(input int p);
      sw_clear[p] = 1'b1;
      ticks(1);
      sw_clear[p] = 1'b0;
   endtask

   localparam logic [3:0] POOL [10] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd8,
                                        4'd9, 4'd10, 4'd11, 4'd12, 4'd5};

   initial begin
      ticks(3);
      rst_n = 1'b1;
      ticks(1);
      // R1
      chk(flag == '0,    "R1 flag",    int'(flag), 0);
      chk(dma_req == '0, "R1 dma_req", int'(dma_req), 0);
      chk(irq == 1'b0,   "R1 irq",     int'(irq), 0);

      // R2: disabled and unlisted codes
      set_code(0, 4'b0000); set_code(1, 4'b0101);
      pin_in[1:0] = 2'b11; ticks(4);
      pin_in[1:0] = 2'b00; ticks(4);
      chk(flag[1:0] == 2'b00, "R2 off/unlisted", int'(flag[1:0]), 0);
      chk(irq == 1'b0, "R2 irq", int'(irq), 0);

      // R3: rising edge, three-edge latency
      set_code(0, 4'b1001);
      pin_in[0] = 1'b1; ticks(2);
      chk(flag[0] == 1'b0, "R3 early", int'(flag[0]), 0);
      ticks(1);
      chk(flag[0] == 1'b1, "R3 set", int'(flag[0]), 1);
      chk(irq == 1'b1, "R8 irq from flag", int'(irq), 1);
      pulse_clear(0);
      chk(flag[0] == 1'b0, "R10 clear", int'(flag[0]), 0);

      // R4: falling edge
      set_code(0, 4'b1010);
      pin_in[0] = 1'b0; ticks(3);
      chk(flag[0] == 1'b1, "R4 fall", int'(flag[0]), 1);
      pulse_clear(0);

      // R5: either edge
      set_code(1, 4'b1011);
      pin_in[1] = 1'b1; ticks(3);
      chk(flag[1] == 1'b1, "R5 rise", int'(flag[1]), 1);
      pulse_clear(1);
      pin_in[1] = 1'b0; ticks(3);
      chk(flag[1] == 1'b1, "R5 fall", int'(flag[1]), 1);
      pulse_clear(1);

      // R7 and R9: DMA rising edge, cleared by transfer completion
      set_code(2, 4'b0001);
      pin_in[2] = 1'b1; ticks(3);
      chk(dma_req[2] == 1'b1, "R7 dma_req", int'(dma_req[2]), 1);
      chk(irq == 1'b0, "R7 no irq", int'(irq), 0);
      dma_done[2] = 1'b1; ticks(1); dma_done[2] = 1'b0;
      chk(flag[2] == 1'b0, "R9 dma_done clears", int'(flag[2]), 0);

      // R9: dma_done ignored in interrupt mode
      set_code(0, 4'b1001);
      pin_in[0] = 1'b1; ticks(3);
      dma_done[0] = 1'b1; ticks(1); dma_done[0] = 1'b0; ticks(1);
      chk(flag[0] == 1'b1, "R9 ignored in irq mode", int'(flag[0]), 1);
      pulse_clear(0);

      // R11: edge coinciding with clear
      set_code(3, 4'b1011);
      pin_in[3] = 1'b1; ticks(3);
      pin_in[3] = 1'b0; ticks(2);
      sw_clear[3] = 1'b1; ticks(1); sw_clear[3] = 1'b0;
      chk(flag[3] == 1'b1, "R11 edge beats clear", int'(flag[3]), 1);
      pulse_clear(3);

      // R6 and R12: high level
      set_code(1, 4'b1100); ticks(3);
      chk(flag[1] == 1'b0, "R6 inactive level", int'(flag[1]), 0);
      pin_in[1] = 1'b1; ticks(3);
      chk(flag[1] == 1'b1, "R6 high level", int'(flag[1]), 1);
      pulse_clear(1);
      chk(flag[1] == 1'b0, "R12 dip", int'(flag[1]), 0);
      ticks(1);
      chk(flag[1] == 1'b1, "R12 re-arm", int'(flag[1]), 1);

      // R8: interrupt follows code change immediately
      set_code(1, 4'b0000); #1;
      chk(irq == 1'b0, "R8 mask by code", int'(irq), 0);
      chk(flag[1] == 1'b1, "R8 flag kept", int'(flag[1]), 1);
      ticks(1);
      pulse_clear(1);

      // R6: low level, and no re-arm once level is gone
      set_code(2, 4'b1000); ticks(2);
      chk(flag[2] == 1'b0, "R6 low inactive", int'(flag[2]), 0);
      pin_in[2] = 1'b0; ticks(3);
      chk(flag[2] == 1'b1, "R6 low level", int'(flag[2]), 1);
      pin_in[2] = 1'b1; ticks(3);
      pulse_clear(2); ticks(1);
      chk(flag[2] == 1'b0, "R12 no re-arm after level", int'(flag[2]), 0);

      // random phase, checked by the model
      for (int i = 0; i < 400; i++) begin
         pin_in = NP'($urandom);
         if ($urandom % 16 == 0) set_code($urandom % NP, POOL[$urandom % 10]);
         for (int p = 0; p < NP; p++) begin
            sw_clear[p] = ($urandom % 8 == 0);
            dma_done[p] = ($urandom % 6 == 0);
         end
         ticks(1);
      end
      sw_clear = '0; dma_done = '0;
      ticks(2);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(PERIOD * 50000);
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule